// File: doc/BRIEF.md
# Trap Entry State Updater

This block applies the architectural side effects of taking a trap on a hart. When the pipeline raises the trap strobe, it presents the trap kind (interrupt or exception), the raw cause number, the pc of the trapping instruction and the faulting address. The block then works out whether the trap is handled at machine level or at supervisor level. It updates that level's cause, exception-pc and trap-value registers and pushes the interrupt-enable stack of that level. It also records the new privilege, produces the handler address for the fetch unit, and emits a one-cycle pulse that drops any outstanding load reservation.

The current privilege and the live machine and supervisor interrupt-enable bits come in from the hart's state logic. The exception and interrupt delegation masks and the two trap vector registers are supplied by the control register file. All updates commit on the clock edge that samples the strobe. Environment calls arrive with a single generic cause number, and the block rewrites that number according to the privilege level the call came from.

Top module: `trap_entry_unit`

## Requirements
- R1: A trap is handled at supervisor level (priv_q = 1) only when cur_priv is 0 or 1 and bit [code] of the delegation mask is set. The mask is ideleg for interrupts and edeleg for exceptions, and code is the cause after R7. Every other trap, including every trap from cur_priv = 3, is handled at machine level (priv_q = 3).
- R2: On supervisor entry, spie_q takes cur_sie, spp_q takes bit 0 of cur_priv, and sie_q becomes 0.
- R3: On machine entry, mpie_q takes cur_mie, mpp_q takes cur_priv, and mie_q becomes 0.
- R4: The selected level's cause register receives the code in bits [4:0] and trap_async in bit 31, with all other bits zero. Its exception-pc register receives trap_pc.
- R5: The selected level's trap-value register receives trap_addr when the trap is an exception with code 0, 1, 4, 5, 6, 7, 12, 13 or 15. For every other trap, including all interrupts, it receives zero.
- R6: pc_next is the selected vector with bits [1:0] cleared. When the vector's bits [1:0] equal 1 and the trap is an interrupt, 4 × code is added. Vector mode values 0, 2 and 3 give the base only.
- R7: An exception with raw cause 8 is rewritten to 8 when cur_priv is 0, to 9 when cur_priv is 1, and to 11 when cur_priv is 3. An interrupt with cause 8 is not rewritten.
- R8: pc_load and resv_clear are high for exactly the one cycle after each accepted trap strobe.
- R9: After reset, priv_q = 3, mie_q = 0, and all cause, pc and value registers, pc_next and both pulses read zero.
- R10: Without the strobe, no register output changes, whatever the other inputs do.
- R11: A supervisor-level trap leaves every machine-level output unchanged, and a machine-level trap leaves every supervisor-level output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_valid | input | 1 | Trap strobe, one cycle per trap |
| trap_async | input | 1 | 1 = interrupt, 0 = exception |
| trap_cause | input | 5 | Raw cause number |
| trap_pc | input | 32 | pc of the trapping instruction |
| trap_addr | input | 32 | Faulting address |
| cur_priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| cur_mie | input | 1 | Live machine interrupt enable |
| cur_sie | input | 1 | Live supervisor interrupt enable |
| edeleg | input | 32 | Exception delegation mask |
| ideleg | input | 32 | Interrupt delegation mask |
| mvec | input | 32 | Machine trap vector (base plus mode in bits [1:0]) |
| svec | input | 32 | Supervisor trap vector (base plus mode in bits [1:0]) |
| priv_q | output | 2 | Privilege after the trap |
| mie_q | output | 1 | Machine interrupt enable |
| mpie_q | output | 1 | Machine prior interrupt enable |
| mpp_q | output | 2 | Machine prior privilege |
| sie_q | output | 1 | Supervisor interrupt enable |
| spie_q | output | 1 | Supervisor prior interrupt enable |
| spp_q | output | 1 | Supervisor prior privilege |
| mcause_q | output | 32 | Machine cause |
| mepc_q | output | 32 | Machine exception pc |
| mtval_q | output | 32 | Machine trap value |
| scause_q | output | 32 | Supervisor cause |
| sepc_q | output | 32 | Supervisor exception pc |
| stval_q | output | 32 | Supervisor trap value |
| pc_next | output | 32 | Handler address |
| pc_load | output | 1 | Handler address valid pulse |
| resv_clear | output | 1 | Load reservation drop pulse |

## Verification
Two functions can act in the same cycle and interact: the environment-call rewrite and the delegation decision. Delegation must index the rewritten code, not the raw one. The bench provokes this by delegating code 8 but not code 9, then issuing a raw cause-8 exception from U level and from S level. The first must land at supervisor level with code 8, and the second must land at machine level with code 9. A second collision is the vectored offset with a cause-8 interrupt. There, the code must stay 8 and the offset must be 32.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [1:0] {
    LVL_USER  = 2'd0,
    LVL_SUPV  = 2'd1,
    LVL_RSVD  = 2'd2,
    LVL_MACH  = 2'd3
  } lvl_e;

  localparam int unsigned CODE_ENV_CALL_U = 8;
  localparam int unsigned CODE_ENV_CALL_S = 9;
  localparam int unsigned CODE_ENV_CALL_M = 11;
  localparam logic [1:0]  VEC_MODE_TABLE  = 2'd1;

  // Exception codes that report a faulting address in the trap-value register
  function automatic logic code_has_addr(input logic [4:0] code);
    case (code)
      5'd0, 5'd1, 5'd4, 5'd5, 5'd6, 5'd7,
      5'd12, 5'd13, 5'd15: code_has_addr = 1'b1;
      default:             code_has_addr = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/trap_code_map.sv
module trap_code_map
  import trap_pkg::*;
#(
  parameter int unsigned CW = 5
) (
  input  logic          is_irq,
  input  logic [CW-1:0] raw_code,
  input  logic [1:0]    from_lvl,
  output logic [CW-1:0] code,
  output logic          addr_kept
);
  always_comb begin
    code = raw_code;
    if (!is_irq && raw_code == CW'(CODE_ENV_CALL_U)) begin
      case (lvl_e'(from_lvl))
        LVL_SUPV: code = CW'(CODE_ENV_CALL_S);
        LVL_MACH: code = CW'(CODE_ENV_CALL_M);
        default:  code = CW'(CODE_ENV_CALL_U);
      endcase
    end
    addr_kept = !is_irq && code_has_addr(5'(code));
  end
endmodule

// File: rtl/trap_route.sv
module trap_route
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned CW   = 5
) (
  input  logic            is_irq,
  input  logic [CW-1:0]   code,
  input  logic [1:0]      from_lvl,
  input  logic [XLEN-1:0] exc_mask,
  input  logic [XLEN-1:0] irq_mask,
  output logic            to_supv
);
  localparam int unsigned MAXCODE = (1 << CW);
  logic [XLEN-1:0] mask;
  logic            bit_set;
  logic            lvl_ok;

  assign mask   = is_irq ? irq_mask : exc_mask;
  assign lvl_ok = (lvl_e'(from_lvl) == LVL_USER) || (lvl_e'(from_lvl) == LVL_SUPV);

  generate
    if (MAXCODE <= XLEN) begin : g_fits
      assign bit_set = mask[code];
    end else begin : g_guard
      assign bit_set = (int'(code) < int'(XLEN)) ? mask[code[$clog2(XLEN)-1:0]] : 1'b0;
    end
  endgenerate

  assign to_supv = lvl_ok && bit_set;
endmodule

// File: rtl/trap_vector.sv
module trap_vector
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned CW   = 5
) (
  input  logic            is_irq,
  input  logic [CW-1:0]   code,
  input  logic [XLEN-1:0] vec,
  output logic [XLEN-1:0] target
);
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;

  assign base   = {vec[XLEN-1:2], 2'b00};
  assign offset = (is_irq && vec[1:0] == VEC_MODE_TABLE) ? (XLEN'(code) << 2) : '0;
  assign target = base + offset;
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned CW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_valid,
  input  logic            trap_async,
  input  logic [CW-1:0]   trap_cause,
  input  logic [XLEN-1:0] trap_pc,
  input  logic [XLEN-1:0] trap_addr,
  input  logic [1:0]      cur_priv,
  input  logic            cur_mie,
  input  logic            cur_sie,
  input  logic [XLEN-1:0] edeleg,
  input  logic [XLEN-1:0] ideleg,
  input  logic [XLEN-1:0] mvec,
  input  logic [XLEN-1:0] svec,
  output logic [1:0]      priv_q,
  output logic            mie_q,
  output logic            mpie_q,
  output logic [1:0]      mpp_q,
  output logic            sie_q,
  output logic            spie_q,
  output logic            spp_q,
  output logic [XLEN-1:0] mcause_q,
  output logic [XLEN-1:0] mepc_q,
  output logic [XLEN-1:0] mtval_q,
  output logic [XLEN-1:0] scause_q,
  output logic [XLEN-1:0] sepc_q,
  output logic [XLEN-1:0] stval_q,
  output logic [XLEN-1:0] pc_next,
  output logic            pc_load,
  output logic            resv_clear
);
  localparam int unsigned PADW = XLEN - 1 - CW;

  logic [CW-1:0]   code;
  logic            addr_kept;
  logic            to_supv;
  logic [XLEN-1:0] m_target;
  logic [XLEN-1:0] s_target;
  logic [XLEN-1:0] cause_word;
  logic [XLEN-1:0] value_word;

  logic            upd_m;
  logic            upd_s;
  logic [1:0]      priv_d;
  logic            mie_d, mpie_d, sie_d, spie_d, spp_d;
  logic [1:0]      mpp_d;
  logic [XLEN-1:0] mcause_d, mepc_d, mtval_d;
  logic [XLEN-1:0] scause_d, sepc_d, stval_d;
  logic [XLEN-1:0] pc_d;

  trap_code_map #(.CW(CW)) u_map (
    .is_irq    (trap_async),
    .raw_code  (trap_cause),
    .from_lvl  (cur_priv),
    .code      (code),
    .addr_kept (addr_kept)
  );

  trap_route #(.XLEN(XLEN), .CW(CW)) u_route (
    .is_irq   (trap_async),
    .code     (code),
    .from_lvl (cur_priv),
    .exc_mask (edeleg),
    .irq_mask (ideleg),
    .to_supv  (to_supv)
  );

  trap_vector #(.XLEN(XLEN), .CW(CW)) u_mvec (
    .is_irq (trap_async),
    .code   (code),
    .vec    (mvec),
    .target (m_target)
  );

  trap_vector #(.XLEN(XLEN), .CW(CW)) u_svec (
    .is_irq (trap_async),
    .code   (code),
    .vec    (svec),
    .target (s_target)
  );

  assign cause_word = {trap_async, {PADW{1'b0}}, code};
  assign value_word = addr_kept ? trap_addr : '0;
  assign upd_m      = trap_valid && !to_supv;
  assign upd_s      = trap_valid && to_supv;

  // Next-state: machine level group
  always_comb begin
    mie_d    = mie_q;
    mpie_d   = mpie_q;
    mpp_d    = mpp_q;
    mcause_d = mcause_q;
    mepc_d   = mepc_q;
    mtval_d  = mtval_q;
    if (upd_m) begin
      mpie_d   = cur_mie;
      mpp_d    = cur_priv;
      mie_d    = 1'b0;
      mcause_d = cause_word;
      mepc_d   = trap_pc;
      mtval_d  = value_word;
    end
  end

  // Next-state: supervisor level group
  always_comb begin
    sie_d    = sie_q;
    spie_d   = spie_q;
    spp_d    = spp_q;
    scause_d = scause_q;
    sepc_d   = sepc_q;
    stval_d  = stval_q;
    if (upd_s) begin
      spie_d   = cur_sie;
      spp_d    = cur_priv[0];
      sie_d    = 1'b0;
      scause_d = cause_word;
      sepc_d   = trap_pc;
      stval_d  = value_word;
    end
  end

  // Next-state: privilege and handler address
  always_comb begin
    priv_d = priv_q;
    pc_d   = pc_next;
    if (trap_valid) begin
      priv_d = to_supv ? 2'(LVL_SUPV) : 2'(LVL_MACH);
      pc_d   = to_supv ? s_target : m_target;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mie_q    <= 1'b0;
      mpie_q   <= 1'b0;
      mpp_q    <= 2'(LVL_USER);
      mcause_q <= '0;
      mepc_q   <= '0;
      mtval_q  <= '0;
    end else if (upd_m) begin
      mie_q    <= mie_d;
      mpie_q   <= mpie_d;
      mpp_q    <= mpp_d;
      mcause_q <= mcause_d;
      mepc_q   <= mepc_d;
      mtval_q  <= mtval_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sie_q    <= 1'b0;
      spie_q   <= 1'b0;
      spp_q    <= 1'b0;
      scause_q <= '0;
      sepc_q   <= '0;
      stval_q  <= '0;
    end else if (upd_s) begin
      sie_q    <= sie_d;
      spie_q   <= spie_d;
      spp_q    <= spp_d;
      scause_q <= scause_d;
      sepc_q   <= sepc_d;
      stval_q  <= stval_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priv_q  <= 2'(LVL_MACH);
      pc_next <= '0;
    end else if (trap_valid) begin
      priv_q  <= priv_d;
      pc_next <= pc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_load    <= 1'b0;
      resv_clear <= 1'b0;
    end else begin
      pc_load    <= trap_valid;
      resv_clear <= trap_valid;
    end
  end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trap_valid,
  input logic [1:0]      cur_priv,
  input logic [1:0]      priv_q,
  input logic            mie_q,
  input logic            sie_q,
  input logic [XLEN-1:0] mcause_q,
  input logic [XLEN-1:0] scause_q,
  input logic [XLEN-1:0] mepc_q,
  input logic [XLEN-1:0] pc_next,
  input logic            pc_load,
  input logic            resv_clear
);
  AST_PULSE_AFTER_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> (pc_load && resv_clear)); // R8
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid |=> (!pc_load && !resv_clear)); // R10
  AST_STATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid |=> ($stable(mcause_q) && $stable(scause_q) && $stable(priv_q))); // R10
  AST_FROM_M_STAYS_M: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && cur_priv == 2'd3) |=> (priv_q == 2'd3)); // R1
  AST_M_ENTRY_MIE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && priv_q == 2'd3) |-> !mie_q); // R3
  AST_S_ENTRY_SIE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && priv_q == 2'd1) |-> !sie_q); // R2
  AST_S_ENTRY_KEEPS_MEPC: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && priv_q == 2'd1) |-> $stable(mepc_q)); // R11
  AST_HANDLER_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (pc_next[1:0] == 2'b00)); // R6
endmodule

bind trap_entry_unit trap_entry_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trap_valid (trap_valid),
  .cur_priv   (cur_priv),
  .priv_q     (priv_q),
  .mie_q      (mie_q),
  .sie_q      (sie_q),
  .mcause_q   (mcause_q),
  .scause_q   (scause_q),
  .mepc_q     (mepc_q),
  .pc_next    (pc_next),
  .pc_load    (pc_load),
  .resv_clear (resv_clear)
);

// File: tb/trap_entry_unit_tb.sv
module trap_entry_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_valid = 1'b0, trap_async = 1'b0;
  logic [4:0]  trap_cause = '0;
  logic [31:0] trap_pc = '0, trap_addr = '0;
  logic [1:0]  cur_priv = 2'd3;
  logic        cur_mie = 1'b0, cur_sie = 1'b0;
  logic [31:0] edeleg = 32'h0000_2100;  // codes 8 and 13
  logic [31:0] ideleg = 32'h0000_0020;  // code 5
  logic [31:0] mvec   = 32'h8000_0101;  // table mode
  logic [31:0] svec   = 32'h4000_0200;  // direct mode
  logic [1:0]  priv_q, mpp_q;
  logic        mie_q, mpie_q, sie_q, spie_q, spp_q, pc_load, resv_clear;
  logic [31:0] mcause_q, mepc_q, mtval_q, scause_q, sepc_q, stval_q, pc_next;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  trap_entry_unit u_dut (.*);

  typedef struct packed {
    logic       async;
    logic [4:0] cause;
    logic [1:0] priv;
    logic       mie;
    logic       sie;
    logic [1:0] exp_lvl;
    logic [4:0] exp_code;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 5'd13, 2'd0, 1'b1, 1'b1, 2'd1, 5'd13},  // delegated page fault from U
    '{1'b0, 5'd13, 2'd3, 1'b1, 1'b0, 2'd3, 5'd13},  // from M never delegated
    '{1'b0, 5'd8,  2'd0, 1'b0, 1'b1, 2'd1, 5'd8},   // U ecall, delegated
    '{1'b0, 5'd8,  2'd1, 1'b1, 1'b0, 2'd3, 5'd9},   // S ecall -> 9, not delegated
    '{1'b0, 5'd8,  2'd3, 1'b0, 1'b0, 2'd3, 5'd11},  // M ecall -> 11
    '{1'b1, 5'd5,  2'd1, 1'b0, 1'b1, 2'd1, 5'd5},   // delegated irq, direct
    '{1'b1, 5'd7,  2'd0, 1'b1, 1'b0, 2'd3, 5'd7},   // irq to M, table
    '{1'b0, 5'd2,  2'd0, 1'b0, 1'b0, 2'd3, 5'd2},   // illegal: no address
    '{1'b0, 5'd3,  2'd1, 1'b1, 1'b1, 2'd3, 5'd3},   // breakpoint: no address
    '{1'b0, 5'd0,  2'd0, 1'b0, 1'b1, 2'd3, 5'd0},   // misaligned fetch
    '{1'b0, 5'd13, 2'd1, 1'b0, 1'b1, 2'd1, 5'd13},  // delegated from S
    '{1'b1, 5'd3,  2'd3, 1'b1, 1'b0, 2'd3, 5'd3},   // irq from M
    '{1'b1, 5'd8,  2'd0, 1'b0, 1'b0, 2'd3, 5'd8},   // irq 8 not rewritten
    '{1'b0, 5'd15, 2'd1, 1'b1, 1'b1, 2'd3, 5'd15}   // store page fault
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fire(input logic a, input logic [4:0] c, input logic [1:0] p,
                      input logic me, input logic se, input logic [31:0] pc,
                      input logic [31:0] ad);
    @(negedge clk);
    trap_async = a; trap_cause = c; cur_priv = p; cur_mie = me; cur_sie = se;
    trap_pc = pc; trap_addr = ad; trap_valid = 1'b1;
    @(negedge clk);
    trap_valid = 1'b0;
  endtask

  function automatic logic has_addr(input logic a, input logic [4:0] c);
    if (a) return 1'b0;
    return (c inside {5'd0, 5'd1, 5'd4, 5'd5, 5'd6, 5'd7, 5'd12, 5'd13, 5'd15});
  endfunction

  function automatic logic [31:0] handler(input logic a, input logic [4:0] c,
                                          input logic [31:0] v);
    logic [31:0] b = {v[31:2], 2'b00};
    if (a && v[1:0] == 2'd1) return b + 32'(c) * 4;
    return b;
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] sv_mcause, sv_mepc, sv_mtval, sv_scause, sv_sepc, sv_stval;
    logic [1:0]  sv_mpp;
    logic        sv_mpie, sv_mie, sv_sie, sv_spie, sv_spp;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 priv", 32'(priv_q), 32'd3);
    chk("R9 mie", 32'(mie_q), 32'd0);
    chk("R9 mcause", mcause_q, 32'd0);
    chk("R9 sepc", sepc_q, 32'd0);
    chk("R9 pc_next", pc_next, 32'd0);
    chk("R9 pulses", {30'd0, pc_load, resv_clear}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      logic [31:0] pc = 32'h0001_0000 + 32'(i) * 4;
      logic [31:0] ad = 32'hDEAD_0000 + 32'(i);
      logic [31:0] cw = {v.async, 26'd0, v.exp_code};
      logic [31:0] tv = has_addr(v.async, v.exp_code) ? ad : 32'd0;
      sv_mcause = mcause_q; sv_mepc = mepc_q; sv_mtval = mtval_q; sv_mpp = mpp_q;
      sv_mpie = mpie_q; sv_mie = mie_q;
      sv_scause = scause_q; sv_sepc = sepc_q; sv_stval = stval_q;
      sv_sie = sie_q; sv_spie = spie_q; sv_spp = spp_q;
      fire(v.async, v.cause, v.priv, v.mie, v.sie, pc, ad);
      chk($sformatf("R1 level v%0d", i), 32'(priv_q), 32'(v.exp_lvl));
      chk($sformatf("R8 pulse v%0d", i), {30'd0, pc_load, resv_clear}, 32'd3);
      if (v.exp_lvl == 2'd1) begin
        chk($sformatf("R4 R7 scause v%0d", i), scause_q, cw);
        chk($sformatf("R4 sepc v%0d", i), sepc_q, pc);
        chk($sformatf("R5 stval v%0d", i), stval_q, tv);
        chk($sformatf("R6 pc v%0d", i), pc_next, handler(v.async, v.exp_code, svec));
        chk($sformatf("R2 stack v%0d", i), {29'd0, sie_q, spie_q, spp_q},
            {29'd0, 1'b0, v.sie, v.priv[0]});
        chk($sformatf("R11 m side v%0d", i), {mcause_q ^ sv_mcause} | {mepc_q ^ sv_mepc}
            | {mtval_q ^ sv_mtval} | 32'({mpp_q, mpie_q, mie_q} ^ {sv_mpp, sv_mpie, sv_mie}), 32'd0);
      end else begin
        chk($sformatf("R4 R7 mcause v%0d", i), mcause_q, cw);
        chk($sformatf("R4 mepc v%0d", i), mepc_q, pc);
        chk($sformatf("R5 mtval v%0d", i), mtval_q, tv);
        chk($sformatf("R6 pc v%0d", i), pc_next, handler(v.async, v.exp_code, mvec));
        chk($sformatf("R3 stack v%0d", i), {28'd0, mie_q, mpie_q, mpp_q},
            {28'd0, 1'b0, v.mie, v.priv});
        chk($sformatf("R11 s side v%0d", i), {scause_q ^ sv_scause} | {sepc_q ^ sv_sepc}
            | {stval_q ^ sv_stval} | 32'({sie_q, spie_q, spp_q} ^ {sv_sie, sv_spie, sv_spp}), 32'd0);
      end
      @(negedge clk);
      chk($sformatf("R8 single v%0d", i), {30'd0, pc_load, resv_clear}, 32'd0);
    end

    // R10: inputs wiggle without strobe
    sv_mcause = mcause_q; sv_scause = scause_q; sv_mepc = mepc_q;
    trap_cause = 5'd1; trap_pc = 32'hFFFF_FFF0; cur_priv = 2'd0; trap_async = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 mcause", mcause_q, sv_mcause);
    chk("R10 scause", scause_q, sv_scause);
    chk("R10 mepc", mepc_q, sv_mepc);
    chk("R10 no pulse", {30'd0, pc_load, resv_clear}, 32'd0);

    // R6: mode 3 behaves as direct for interrupts
    mvec = 32'h8000_0103;
    fire(1'b1, 5'd7, 2'd3, 1'b0, 1'b0, 32'h100, 32'h0);
    chk("R6 mode3 direct", pc_next, 32'h8000_0100);
    // R6: exception under table mode gets no offset
    mvec = 32'h8000_0101;
    fire(1'b0, 5'd5, 2'd0, 1'b0, 1'b0, 32'h104, 32'hABCD_0000);
    chk("R6 exc no offset", pc_next, 32'h8000_0100);
    chk("R5 load fault addr", mtval_q, 32'hABCD_0000);

    // R1: delegated code but origin M stays M; undelegated from S goes M
    fire(1'b1, 5'd5, 2'd3, 1'b0, 1'b0, 32'h108, 32'h0);
    chk("R1 M origin delegated irq", 32'(priv_q), 32'd3);
    fire(1'b0, 5'd12, 2'd1, 1'b0, 1'b0, 32'h10C, 32'h55);
    chk("R1 S origin undelegated", 32'(priv_q), 32'd3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule